// File: doc/BRIEF.md
# Dual Coulomb Counter with Coherent Snapshot

This block keeps two free-running 32-bit tallies of charge quanta. One counts pulses that arrive while current flows into the battery and the other counts pulses that arrive while current flows out. Neither tally ever counts down. The host reads the tallies through a 16-bit word path, and each command reaches the block as an already-decoded strobe with an 8-bit code.

A full 32-bit value takes two word transactions to read. Between those two transactions a carry out of the lower half could corrupt the result, so the block reads through a snapshot register. The low-half read command captures the selected tally and returns its lower half. It also enables refresh, so any later command that is not the high-half read captures the tally again. The high-half read command turns refresh off and returns the upper half of the value that is already stored, so both halves come from one capture. An offset-measurement input freezes both tallies while the analog front end calibrates.

Top module: `dual_coulomb_snap`

## Requirements
- R1: After reset both tallies are zero, the snapshot is zero, refresh is off and the read word is zero.
- R2: A single-cycle charge strobe adds one to the charge tally only. A single-cycle discharge strobe adds one to the discharge tally only.
- R3: A clear strobe zeroes both tallies on the next clock edge. A clear takes priority over an increment in the same cycle.
- R4: A tally that holds its all-ones value wraps to zero on the next increment and keeps counting. No flag is raised.
- R5: The select input picks the source for the snapshot: 1 selects the charge tally and 0 selects the discharge tally.
- R6: Command code 0x82 copies the selected tally into the snapshot and turns refresh on. The read word then carries the lower half of that same copy: bits 7:0 hold snapshot byte 0 and bits 15:8 hold snapshot byte 1.
- R7: While refresh is on, any command other than 0x83 copies the selected tally into the snapshot again.
- R8: Command code 0x83 turns refresh off without a new copy. The read word then carries the upper half of the stored snapshot: bits 7:0 hold byte 2 and bits 15:8 hold byte 3. While refresh is off, commands other than 0x82 leave the snapshot unchanged.
- R9: While offset measurement is active, increment strobes are ignored and both tallies hold their values.
- R10: The read word changes only on a 0x82 or 0x83 command and keeps its value across any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| chg_inc | input | 1 | Single-cycle charge-direction count strobe |
| dis_inc | input | 1 | Single-cycle discharge-direction count strobe |
| sel_chg | input | 1 | Snapshot source: 1 selects the charge tally, 0 selects the discharge tally |
| clr_cnt | input | 1 | Clears both tallies |
| offset_meas | input | 1 | Offset-measurement mode; blocks increments while high |
| cmd_vld | input | 1 | Single-cycle strobe that marks a newly received command |
| cmd_code | input | 8 | Code of the command that cmd_vld marks |
| rd_word | output | 16 | Read data, valid from the clock edge that samples a read command |

## Verification
The properties assume that cmd_vld is a single-cycle strobe and that cmd_code is meaningful only in the cycle where cmd_vld is high. They also assume that sel_chg is settled in a command cycle. The stimulus drives every input on the falling clock edge. It holds each command strobe for exactly one cycle and leaves at least one idle cycle between commands. It changes the select input only in cycles that carry no command. A clear is issued together with an increment once, to exercise the priority rule. Wrap-around is reached by running a narrower parameterisation of the tallies up to their all-ones value.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int CMD_W = 8;
  localparam logic [CMD_W-1:0] CMD_SNAP_LO = 8'h82;
  localparam logic [CMD_W-1:0] CMD_SNAP_HI = 8'h83;

  // direction index doubles as the select encoding (1 = charge)
  localparam int DIR_DIS = 0;
  localparam int DIR_CHG = 1;
  localparam int N_DIR   = 2;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_LO    = 2'd1,
    ACT_HI    = 2'd2,
    ACT_OTHER = 2'd3
  } cmd_act_e;

  function automatic cmd_act_e decode_cmd(input logic vld, input logic [CMD_W-1:0] code);
    cmd_act_e a;
    if (!vld)                     a = ACT_NONE;
    else if (code == CMD_SNAP_LO) a = ACT_LO;
    else if (code == CMD_SNAP_HI) a = ACT_HI;
    else                          a = ACT_OTHER;
    return a;
  endfunction
endpackage

// File: rtl/ccs_counter.sv
module ccs_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic         hold,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic         q_en;
  logic [W-1:0] q_nxt;

  // clear wins over a same-cycle increment; wrap is natural modulo 2^W
  always_comb begin
    q_en  = clr | (inc & ~hold);
    q_nxt = clr ? '0 : (q + ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (q_en)  q <= q_nxt;
  end
endmodule

// File: rtl/ccs_snapshot.sv
module ccs_snapshot
  import ccs_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_vld,
  input  logic [CMD_W-1:0]   cmd_code,
  input  logic [CNT_W-1:0]   src,
  output logic [CNT_W/2-1:0] rd_word,
  output logic               upd_en,
  output logic [CNT_W-1:0]   snap
);
  localparam int HW = CNT_W / 2;

  cmd_act_e          act;
  logic              upd_nxt;
  logic              snap_en;
  logic [CNT_W-1:0]  snap_nxt;
  logic              rd_en;
  logic [HW-1:0]     rd_nxt;

  always_comb begin
    act      = decode_cmd(cmd_vld, cmd_code);
    upd_nxt  = upd_en;
    snap_en  = 1'b0;
    snap_nxt = src;
    rd_en    = 1'b0;
    rd_nxt   = rd_word;
    unique case (act)
      ACT_LO: begin
        upd_nxt = 1'b1;
        snap_en = 1'b1;
        rd_en   = 1'b1;
        rd_nxt  = src[HW-1:0];        // bypass: low half of the copy taken now
      end
      ACT_HI: begin
        upd_nxt = 1'b0;
        rd_en   = 1'b1;
        rd_nxt  = snap[CNT_W-1:HW];
      end
      ACT_OTHER: begin
        snap_en = upd_en;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_en  <= 1'b0;
      snap    <= '0;
      rd_word <= '0;
    end else begin
      upd_en <= upd_nxt;
      if (snap_en) snap    <= snap_nxt;
      if (rd_en)   rd_word <= rd_nxt;
    end
  end
endmodule

// File: rtl/dual_coulomb_snap.sv
module dual_coulomb_snap
  import ccs_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chg_inc,
  input  logic               dis_inc,
  input  logic               sel_chg,
  input  logic               clr_cnt,
  input  logic               offset_meas,
  input  logic               cmd_vld,
  input  logic [CMD_W-1:0]   cmd_code,
  output logic [CNT_W/2-1:0] rd_word
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync[SYNC_N-1];

  logic [N_DIR-1:0] inc_v;
  logic [CNT_W-1:0] cnt_q [N_DIR];
  logic [CNT_W-1:0] sel_cnt;
  logic [CNT_W-1:0] chg_cnt;
  logic [CNT_W-1:0] dis_cnt;
  logic [CNT_W-1:0] snap;
  logic             upd_en;

  assign inc_v[DIR_CHG] = chg_inc;
  assign inc_v[DIR_DIS] = dis_inc;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    ccs_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_int_n),
      .clr   (clr_cnt),
      .inc   (inc_v[d]),
      .hold  (offset_meas),
      .q     (cnt_q[d])
    );
  end

  assign chg_cnt = cnt_q[DIR_CHG];
  assign dis_cnt = cnt_q[DIR_DIS];
  assign sel_cnt = sel_chg ? chg_cnt : dis_cnt;

  ccs_snapshot #(.CNT_W(CNT_W)) u_snap (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmd_vld  (cmd_vld),
    .cmd_code (cmd_code),
    .src      (sel_cnt),
    .rd_word  (rd_word),
    .upd_en   (upd_en),
    .snap     (snap)
  );
endmodule

// File: rtl/ccs_checker.sv
module ccs_checker
  import ccs_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               chg_inc,
  input logic               dis_inc,
  input logic               sel_chg,
  input logic               clr_cnt,
  input logic               offset_meas,
  input logic               cmd_vld,
  input logic [CMD_W-1:0]   cmd_code,
  input logic [CNT_W/2-1:0] rd_word,
  input logic [CNT_W-1:0]   chg_cnt,
  input logic [CNT_W-1:0]   dis_cnt,
  input logic [CNT_W-1:0]   snap,
  input logic               upd_en
);
  localparam int HW = CNT_W / 2;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  p_chg_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chg_inc && !clr_cnt && !offset_meas |=> chg_cnt == $past(chg_cnt) + ONE);

  p_dis_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dis_inc && !clr_cnt && !offset_meas |=> dis_cnt == $past(dis_cnt) + ONE);

  p_dis_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_inc && !clr_cnt |=> $stable(dis_cnt));

  p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt |=> chg_cnt == '0 && dis_cnt == '0);

  p_offset_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    offset_meas && !clr_cnt |=> $stable(chg_cnt) && $stable(dis_cnt));

  p_low_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd_code == CMD_SNAP_LO |=>
      upd_en && rd_word == $past(sel_chg ? chg_cnt[HW-1:0] : dis_cnt[HW-1:0]));

  p_refresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && upd_en && cmd_code != CMD_SNAP_HI |=>
      snap == $past(sel_chg ? chg_cnt : dis_cnt));

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && !upd_en && cmd_code != CMD_SNAP_LO |=> $stable(snap));

  p_high_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd_code == CMD_SNAP_HI |=> !upd_en && rd_word == $past(snap[CNT_W-1:HW]));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> $stable(rd_word));
endmodule

bind dual_coulomb_snap ccs_checker #(.CNT_W(CNT_W)) u_ccs_checker (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .chg_inc     (chg_inc),
  .dis_inc     (dis_inc),
  .sel_chg     (sel_chg),
  .clr_cnt     (clr_cnt),
  .offset_meas (offset_meas),
  .cmd_vld     (cmd_vld),
  .cmd_code    (cmd_code),
  .rd_word     (rd_word),
  .chg_cnt     (chg_cnt),
  .dis_cnt     (dis_cnt),
  .snap        (snap),
  .upd_en      (upd_en)
);

// File: tb/test_dual_coulomb_snap.sv
module test_dual_coulomb_snap;
  localparam int W  = 12;
  localparam int HW = W / 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          chg_inc, dis_inc, sel_chg, clr_cnt, offset_meas, cmd_vld;
  logic [7:0]    cmd_code;
  logic [HW-1:0] rd_word;

  always #4 clk = ~clk;

  dual_coulomb_snap #(.CNT_W(W)) i_dual_coulomb_snap (
    .clk(clk), .rst_n(rst_n), .chg_inc(chg_inc), .dis_inc(dis_inc),
    .sel_chg(sel_chg), .clr_cnt(clr_cnt), .offset_meas(offset_meas),
    .cmd_vld(cmd_vld), .cmd_code(cmd_code), .rd_word(rd_word)
  );

  int total = 0;
  int bad   = 0;

  // reference model
  logic [W-1:0]  m_chg, m_dis, m_snap;
  logic          m_upd;
  logic [HW-1:0] m_rd;

  logic [HW-1:0] exp_q[$];
  string         tag_q[$];

  task automatic check(input string tag, input logic [HW-1:0] got, input logic [HW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: rd_word got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic pulse(input bit c, input bit d, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chg_inc = c;
      dis_inc = d;
      if (!offset_meas) begin
        if (c) m_chg = m_chg + 1'b1;
        if (d) m_dis = m_dis + 1'b1;
      end
    end
    @(negedge clk);
    chg_inc = 1'b0;
    dis_inc = 1'b0;
  endtask

  task automatic clear_with_inc;
    @(negedge clk);
    clr_cnt = 1'b1;
    chg_inc = 1'b1;
    m_chg = '0;
    m_dis = '0;
    @(negedge clk);
    clr_cnt = 1'b0;
    chg_inc = 1'b0;
  endtask

  task automatic set_sel(input logic v);
    @(negedge clk);
    sel_chg = v;
  endtask

  // driver: issues a command and pushes the expected read word
  task automatic command(input logic [7:0] code, input string tag);
    @(negedge clk);
    if (code == 8'h82) begin
      m_snap = sel_chg ? m_chg : m_dis;
      m_upd  = 1'b1;
      m_rd   = m_snap[HW-1:0];
    end else if (code == 8'h83) begin
      m_upd = 1'b0;
      m_rd  = m_snap[W-1:HW];
    end else if (m_upd) begin
      m_snap = sel_chg ? m_chg : m_dis;
    end
    exp_q.push_back(m_rd);
    tag_q.push_back(tag);
    cmd_vld  = 1'b1;
    cmd_code = code;
    @(negedge clk);
    cmd_vld  = 1'b0;
    cmd_code = 8'h00;
  endtask

  // monitor: compares after each clock edge that sampled a command
  initial begin
    forever begin
      logic armed;
      @(posedge clk);
      armed = cmd_vld;
      #2;
      if (armed && exp_q.size() > 0) begin
        logic [HW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rd_word, e);
      end
    end
  end

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog (all requirements): got=timeout exp=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; chg_inc = 0; dis_inc = 0; sel_chg = 0; clr_cnt = 0;
    offset_meas = 0; cmd_vld = 0; cmd_code = 8'h00;
    m_chg = '0; m_dis = '0; m_snap = '0; m_upd = 1'b0; m_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 reset read word", rd_word, '0);
    command(8'h83, "R1 snapshot upper after reset");

    // R2 / R5 / R6: independent tallies and select
    set_sel(1'b1);
    pulse(1, 0, 5);
    pulse(0, 1, 3);
    command(8'h82, "R2 R5 charge tally low half");
    set_sel(1'b0);
    command(8'h82, "R2 R5 discharge tally low half");

    // R6: coherent halves across a carry into the upper half
    set_sel(1'b1);
    pulse(1, 0, 58);
    command(8'h82, "R6 low half at 63");
    pulse(1, 0, 1);
    command(8'h83, "R6 upper half from the same copy");
    command(8'h82, "R6 low half after carry");
    command(8'h83, "R6 upper half after carry");

    // R7 / R10: refresh while enabled, read word held on other commands
    command(8'h82, "R6 enable refresh");
    pulse(1, 0, 70);
    command(8'h10, "R10 other command keeps read word");
    command(8'h83, "R7 refreshed upper half");

    // R8: refresh off, snapshot frozen
    pulse(1, 0, 64);
    command(8'h10, "R10 other command while frozen");
    command(8'h83, "R8 frozen upper half");

    // R9: offset measurement blocks increments
    @(negedge clk); offset_meas = 1'b1;
    pulse(1, 1, 10);
    @(negedge clk); offset_meas = 1'b0;
    command(8'h82, "R9 charge low half after hold");
    command(8'h83, "R9 charge upper half after hold");
    set_sel(1'b0);
    command(8'h82, "R9 discharge low half after hold");

    // R3: clear beats same-cycle increment
    clear_with_inc();
    command(8'h82, "R3 discharge cleared");
    set_sel(1'b1);
    command(8'h82, "R3 charge cleared despite increment");

    // R4: wrap-around
    pulse(1, 0, (1 << W) - 1);
    command(8'h82, "R4 all-ones low half");
    command(8'h83, "R4 all-ones upper half");
    pulse(1, 0, 1);
    command(8'h82, "R4 wrapped low half");
    command(8'h83, "R4 wrapped upper half");
    pulse(1, 0, 2);
    command(8'h82, "R4 counting resumes after wrap");

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule